// File: doc/BRIEF.md
# Time-Tagged Event Recording Buffer

The block stores change-of-state events in the order they arrive. Each stored entry holds a 6-bit channel number, the level the input moved to, and a 16-bit relative time tag. The tag is the value of an internal microsecond timer in the cycle the event is presented. The timer counts external 1 µs enable pulses and spans up to 65.535 ms before it wraps. The host can zero the timer and can start or stop it.

The host drains the buffer in FIFO order. The oldest entry is always visible on the head outputs, and a pop request removes it. The block reports the current event count. It compares that count against a host-programmed maximum and raises a threshold flag when the maximum is reached. When the buffer is full, further events are lost and a sticky overflow flag records the loss.

Top module: `soe_buffer`

## Requirements
- R1: After reset the event count is 0, `empty_o` is 1, the timer reads 0 and is stopped (`tick_i` pulses leave it at 0), the maximum count is 0, and `thr_o` and `ovf_o` are 0.
- R2: While running, the timer rises by 1 on each clock edge where `tick_i` is high. A `tmr_stop_i` pulse freezes it and a `tmr_start_i` pulse resumes it. When both pulses arrive in the same cycle, stop wins.
- R3: The timer wraps from 65535 to 0 on the next tick.
- R4: A `tmr_clr_i` pulse sets the timer to 0 on that edge, even when a tick arrives in the same cycle. The clear leaves the running state unchanged.
- R5: A stored entry carries the channel, the level and the timer value present in the cycle `evt_valid_i` was high.
- R6: Entries leave in arrival order. The head outputs show the oldest entry. A pop while `empty_o` is 1 has no effect.
- R7: Each accepted event adds 1 to `count_o` and each effective pop subtracts 1. A push and a pop in the same cycle leave the count unchanged.
- R8: At 256 entries `full_o` is 1. An event arriving without a pop is dropped and sets `ovf_o`, which stays set until `ovf_clr_i` is pulsed. An event arriving together with a pop on a full buffer is accepted.
- R9: With a nonzero maximum, `thr_o` rises on the clock edge after `count_o` first becomes equal to or greater than the maximum. With a maximum of 0 it never rises.
- R10: `thr_o` falls on the edge after `count_o` drops below the maximum. It also falls on a `thr_clr_i` pulse and does not rise again until the count has left the maximum and returned to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 1 µs enable pulse for the timer |
| tmr_clr_i | input | 1 | Zero the timer |
| tmr_start_i | input | 1 | Start the timer |
| tmr_stop_i | input | 1 | Stop the timer |
| timer_o | output | 16 | Current timer value |
| timer_run_o | output | 1 | Timer running |
| evt_valid_i | input | 1 | Event present this cycle |
| evt_chan_i | input | 6 | Channel of the event |
| evt_level_i | input | 1 | New input level |
| pop_i | input | 1 | Remove the head entry |
| head_chan_o | output | 6 | Channel of the oldest entry |
| head_level_o | output | 1 | Level of the oldest entry |
| head_tag_o | output | 16 | Time tag of the oldest entry |
| count_o | output | 9 | Stored event count |
| empty_o | output | 1 | No entries stored |
| full_o | output | 1 | 256 entries stored |
| max_wr_i | input | 1 | Load the maximum count |
| max_val_i | input | 9 | Maximum count value |
| thr_clr_i | input | 1 | Clear the threshold flag |
| thr_o | output | 1 | Maximum count reached |
| ovf_clr_i | input | 1 | Clear the overflow flag |
| ovf_o | output | 1 | Event lost on a full buffer |

## Verification
The bench aims at the timer edges. A design that counted while stopped, let start beat stop, or let an increment beat a clear would give wrong tags, and a design that saturated instead of wrapping would read 65535 after the extra tick. In the buffer, the bench pops an empty buffer and pushes and pops in the same cycle. A wrong design would underflow the count there, or drop an event that should be kept when the buffer is full. The threshold flag is checked against its one-cycle lag, against a host clear while the count stays at the maximum (a level-set design would set the flag again at once), and against a maximum of zero.

// File: rtl/soe_pkg.sv
package soe_pkg;
  localparam int CHAN_W = 6;
  localparam int TAG_W  = 16;

  typedef struct packed {
    logic [CHAN_W-1:0] chan;
    logic              level;
    logic [TAG_W-1:0]  tag;
  } soe_entry_t;
endpackage

// File: rtl/soe_timer.sv
module soe_timer #(
  parameter int TAG_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic             start_i,
  input  logic             stop_i,
  output logic [TAG_W-1:0] value_o,
  output logic             run_o
);
  logic [TAG_W-1:0] val_q;
  logic             run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= '0;
      run_q <= 1'b0;
    end else begin
      if (stop_i)       run_q <= 1'b0;
      else if (start_i) run_q <= 1'b1;
      // clear beats increment; natural wrap at all-ones
      if (clr_i)                val_q <= '0;
      else if (run_q && tick_i) val_q <= val_q + TAG_W'(1);
    end
  end

  assign value_o = val_q;
  assign run_o   = run_q;
endmodule

// File: rtl/soe_fifo.sv
module soe_fifo
  import soe_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  soe_entry_t       entry_i,
  input  logic             pop_i,
  output soe_entry_t       head_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             drop_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  soe_entry_t       mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             push_ok, pop_ok;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign pop_ok  = pop_i && !empty_o;
  // a full buffer still takes an event when the head leaves in the same cycle
  assign push_ok = push_i && (!full_o || pop_ok);
  assign drop_o  = push_i && !push_ok;

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_ptr_q] <= entry_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= ptr_next(wr_ptr_q);
      if (pop_ok)  rd_ptr_q <= ptr_next(rd_ptr_q);
      unique case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_o  = mem_q[rd_ptr_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/soe_threshold.sv
module soe_threshold #(
  parameter int CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             max_wr_i,
  input  logic [CNT_W-1:0] max_val_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] max_o,
  output logic             flag_o
);
  logic [CNT_W-1:0] max_q;
  logic             reached, reached_q, flag_q;

  assign reached = (max_q != '0) && (cnt_i >= max_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      max_q     <= '0;
      reached_q <= 1'b0;
      flag_q    <= 1'b0;
    end else begin
      if (max_wr_i) max_q <= max_val_i;
      reached_q <= reached;
      // set only on entry into the reached state, so a host clear sticks
      if (!reached)                   flag_q <= 1'b0;
      else if (reached && !reached_q) flag_q <= 1'b1;
      else if (clr_i)                 flag_q <= 1'b0;
    end
  end

  assign max_o  = max_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/soe_buffer.sv
module soe_buffer
  import soe_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              tmr_clr_i,
  input  logic              tmr_start_i,
  input  logic              tmr_stop_i,
  output logic [TAG_W-1:0]  timer_o,
  output logic              timer_run_o,
  input  logic              evt_valid_i,
  input  logic [CHAN_W-1:0] evt_chan_i,
  input  logic              evt_level_i,
  input  logic              pop_i,
  output logic [CHAN_W-1:0] head_chan_o,
  output logic              head_level_o,
  output logic [TAG_W-1:0]  head_tag_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              empty_o,
  output logic              full_o,
  input  logic              max_wr_i,
  input  logic [CNT_W-1:0]  max_val_i,
  input  logic              thr_clr_i,
  output logic              thr_o,
  input  logic              ovf_clr_i,
  output logic              ovf_o
);
  soe_entry_t       new_entry, head;
  logic             drop;
  logic             ovf_q;
  logic [CNT_W-1:0] max_cnt;

  soe_timer #(.TAG_W(TAG_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .clr_i   (tmr_clr_i),
    .start_i (tmr_start_i),
    .stop_i  (tmr_stop_i),
    .value_o (timer_o),
    .run_o   (timer_run_o)
  );

  assign new_entry.chan  = evt_chan_i;
  assign new_entry.level = evt_level_i;
  assign new_entry.tag   = timer_o;

  soe_fifo #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (evt_valid_i),
    .entry_i (new_entry),
    .pop_i   (pop_i),
    .head_o  (head),
    .count_o (count_o),
    .full_o  (full_o),
    .empty_o (empty_o),
    .drop_o  (drop)
  );

  assign head_chan_o  = head.chan;
  assign head_level_o = head.level;
  assign head_tag_o   = head.tag;

  soe_threshold #(.CNT_W(CNT_W)) u_thr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cnt_i     (count_o),
    .max_wr_i  (max_wr_i),
    .max_val_i (max_val_i),
    .clr_i     (thr_clr_i),
    .max_o     (max_cnt),
    .flag_o    (thr_o)
  );

  // a loss in the same cycle as a clear is kept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovf_q <= 1'b0;
    else if (drop)      ovf_q <= 1'b1;
    else if (ovf_clr_i) ovf_q <= 1'b0;
  end

  assign ovf_o = ovf_q;
endmodule

// File: rtl/soe_buffer_chk.sv
module soe_buffer_chk #(
  parameter int CNT_W = 9,
  parameter int TAG_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             tmr_clr_i,
  input logic             run,
  input logic [TAG_W-1:0] timer,
  input logic             evt_valid_i,
  input logic             pop_i,
  input logic [CNT_W-1:0] count,
  input logic             empty,
  input logic             full,
  input logic [CNT_W-1:0] max_cnt,
  input logic             thr,
  input logic             ovf_clr_i,
  input logic             ovf
);
  // R2
  timer_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !tmr_clr_i) |=> (timer == $past(timer)));

  // R3
  timer_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && tick_i && !tmr_clr_i) |=> (timer == $past(timer) + TAG_W'(1)));

  // R4
  timer_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_clr_i |=> (timer == '0));

  // R7
  count_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && !full && !pop_i) |=> (count == $past(count) + CNT_W'(1)));

  // R6
  pop_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty && !evt_valid_i) |=> empty);

  // R8
  full_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && full && !pop_i) |=> (ovf && full));

  // R8
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf && !ovf_clr_i) |=> ovf);

  // R9
  thr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (max_cnt == '0) |=> !thr);
endmodule

bind soe_buffer soe_buffer_chk #(.CNT_W(CNT_W), .TAG_W(soe_pkg::TAG_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .tmr_clr_i   (tmr_clr_i),
  .run         (timer_run_o),
  .timer       (timer_o),
  .evt_valid_i (evt_valid_i),
  .pop_i       (pop_i),
  .count       (count_o),
  .empty       (empty_o),
  .full        (full_o),
  .max_cnt     (max_cnt),
  .thr         (thr_o),
  .ovf_clr_i   (ovf_clr_i),
  .ovf         (ovf_o)
);

// File: tb/soe_buffer_bench.sv
module soe_buffer_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0, tmr_clr_i = 1'b0, tmr_start_i = 1'b0, tmr_stop_i = 1'b0;
  logic [15:0] timer_o;
  logic       timer_run_o;
  logic       evt_valid_i = 1'b0;
  logic [5:0] evt_chan_i = '0;
  logic       evt_level_i = 1'b0;
  logic       pop_i = 1'b0;
  logic [5:0] head_chan_o;
  logic       head_level_o;
  logic [15:0] head_tag_o;
  logic [8:0] count_o;
  logic       empty_o, full_o;
  logic       max_wr_i = 1'b0;
  logic [8:0] max_val_i = '0;
  logic       thr_clr_i = 1'b0, thr_o;
  logic       ovf_clr_i = 1'b0, ovf_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #10 clk_i = ~clk_i;

  soe_buffer u_soe_buffer (.*);

  typedef struct packed {
    logic [15:0] gap;
    logic [5:0]  chan;
    logic        lvl;
    logic [15:0] tag;
  } vec_t;

  // ticks before the event, channel, level, expected tag
  localparam vec_t VEC [5] = '{
    '{16'd3,   6'd5,  1'b1, 16'd3},
    '{16'd0,   6'd63, 1'b0, 16'd3},
    '{16'd10,  6'd0,  1'b1, 16'd13},
    '{16'd1,   6'd17, 1'b0, 16'd14},
    '{16'd200, 6'd42, 1'b1, 16'd214}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      tick_i = 1'b1;
      repeat (n) @(negedge clk_i);
      tick_i = 1'b0;
    end
  endtask

  task automatic pulse_start(); tmr_start_i = 1'b1; @(negedge clk_i); tmr_start_i = 1'b0; endtask
  task automatic pulse_stop();  tmr_stop_i  = 1'b1; @(negedge clk_i); tmr_stop_i  = 1'b0; endtask
  task automatic pulse_pop();   pop_i       = 1'b1; @(negedge clk_i); pop_i       = 1'b0; endtask

  task automatic push(input logic [5:0] ch, input logic lv);
    evt_valid_i = 1'b1; evt_chan_i = ch; evt_level_i = lv;
    @(negedge clk_i);
    evt_valid_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    n_err++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    finish_run();
  end

  initial begin
    // R1 reset state
    do_reset();
    chk("R1 count", count_o, 0);
    chk("R1 empty", empty_o, 1);
    chk("R1 timer", timer_o, 0);
    chk("R1 thr", thr_o, 0);
    chk("R1 ovf", ovf_o, 0);
    ticks(5);
    chk("R1 timer stopped", timer_o, 0);

    // R5 R6 vector table
    pulse_start();
    foreach (VEC[i]) begin
      ticks(int'(VEC[i].gap));
      push(VEC[i].chan, VEC[i].lvl);
    end
    chk("R7 count after table", count_o, 5);
    chk("R2 timer after ticks", timer_o, 214);
    foreach (VEC[i]) begin
      chk("R6 head chan", head_chan_o, VEC[i].chan);
      chk("R5 head level", head_level_o, VEC[i].lvl);
      chk("R5 head tag", head_tag_o, VEC[i].tag);
      pulse_pop();
      chk("R7 count after pop", count_o, 4 - i);
    end
    pulse_pop();
    chk("R6 pop empty count", count_o, 0);
    chk("R6 pop empty flag", empty_o, 1);

    // R2 stop, and stop beats start
    pulse_stop();
    ticks(4);
    chk("R2 stopped", timer_o, 214);
    tmr_start_i = 1'b1; tmr_stop_i = 1'b1;
    @(negedge clk_i);
    tmr_start_i = 1'b0; tmr_stop_i = 1'b0;
    ticks(2);
    chk("R2 stop wins", timer_o, 214);

    // R4 clear beats tick, run state kept
    pulse_start();
    tick_i = 1'b1; tmr_clr_i = 1'b1;
    @(negedge clk_i);
    tick_i = 1'b0; tmr_clr_i = 1'b0;
    chk("R4 clear", timer_o, 0);
    ticks(1);
    chk("R4 still running", timer_o, 1);

    // R3 wrap
    tmr_clr_i = 1'b1; @(negedge clk_i); tmr_clr_i = 1'b0;
    ticks(65535);
    chk("R3 top", timer_o, 65535);
    ticks(1);
    chk("R3 wrap", timer_o, 0);

    // R7 push and pop together
    do_reset();
    push(6'd9, 1'b1);
    evt_valid_i = 1'b1; evt_chan_i = 6'd10; evt_level_i = 1'b0; pop_i = 1'b1;
    @(negedge clk_i);
    evt_valid_i = 1'b0; pop_i = 1'b0;
    chk("R7 push+pop count", count_o, 1);
    chk("R7 push+pop head", head_chan_o, 10);

    // R9 R10 threshold
    do_reset();
    max_wr_i = 1'b1; max_val_i = 9'd3; @(negedge clk_i); max_wr_i = 1'b0;
    push(6'd1, 1'b1);
    push(6'd2, 1'b1);
    @(negedge clk_i);
    chk("R9 below max", thr_o, 0);
    push(6'd3, 1'b1);
    chk("R9 lag", thr_o, 0);
    @(negedge clk_i);
    chk("R9 reached", thr_o, 1);
    pulse_pop();
    @(negedge clk_i);
    chk("R10 below max", thr_o, 0);
    push(6'd4, 1'b0);
    @(negedge clk_i);
    chk("R9 reached again", thr_o, 1);
    thr_clr_i = 1'b1; @(negedge clk_i); thr_clr_i = 1'b0;
    chk("R10 host clear", thr_o, 0);
    repeat (3) @(negedge clk_i);
    chk("R10 clear sticks", thr_o, 0);

    do_reset();
    push(6'd1, 1'b1);
    repeat (2) @(negedge clk_i);
    chk("R9 zero max", thr_o, 0);

    // R8 full and overflow
    do_reset();
    for (int i = 0; i < 256; i++) begin
      evt_valid_i = 1'b1; evt_chan_i = i[5:0]; evt_level_i = 1'b1;
      @(negedge clk_i);
    end
    evt_valid_i = 1'b0;
    chk("R8 full", full_o, 1);
    chk("R8 count full", count_o, 256);
    chk("R8 no ovf yet", ovf_o, 0);
    push(6'd50, 1'b0);
    chk("R8 dropped count", count_o, 256);
    chk("R8 ovf set", ovf_o, 1);
    chk("R8 head kept", head_chan_o, 0);
    evt_valid_i = 1'b1; evt_chan_i = 6'd51; pop_i = 1'b1;
    @(negedge clk_i);
    evt_valid_i = 1'b0; pop_i = 1'b0;
    chk("R8 push with pop", count_o, 256);
    chk("R8 head after pop", head_chan_o, 1);
    chk("R8 ovf sticky", ovf_o, 1);
    ovf_clr_i = 1'b1; @(negedge clk_i); ovf_clr_i = 1'b0;
    chk("R8 ovf clear", ovf_o, 0);

    finish_run();
  end
endmodule